// File: doc/BRIEF.md
# Timestamp Event Queue

This block collects time-stamped events from several sources and holds them in an ordered queue until software takes them out. The sources are a software request, a bank of eight asynchronous hardware edge inputs, and Ethernet receive or transmit capture requests coming from a packet parser. Every event is tagged with the current value of an external 64-bit time counter. It also carries a packed descriptor that identifies the protocol message (sequence number, message type and domain), the kind of event, and the port it came from.

Software reads the oldest entry as four 32-bit words and then strobes a pop input to discard it. A pending flag stays high while the queue holds anything. An interrupt output follows that flag, gated by an interrupt enable. Events that cannot be stored are discarded, and a sticky overflow flag records that this happened. The time counter and the packet parser are outside this block.

Top module: `ts_event_fifo`

## Requirements
- R1: The queue holds up to 16 entries and returns them in the order they were stored.
- R2: Descriptor word 1 packs the sequence ID in bits 15:0, the message type in 19:16, the event type in 23:20 and the port number in 28:24, and reads bits 31:29 as zero.
- R3: Descriptor word 2 carries the 8-bit domain in bits 7:0 and reads bits 31:8 as zero.
- R4: Event type codes are 0 for a software request, 3 for a hardware input, 4 for packet receive and 5 for packet transmit; codes 1, 2, 6 and 7 are reserved for rollover, half rollover, compare and host transmit.
- R5: Hardware input i passes through a two-stage synchronizer. It raises one event per rising edge, only when control bit 8+i is set, and that event reports port number i+1. An input held high raises no further events.
- R6: The pending output is high exactly when the queue is non-empty. The interrupt output is the pending flag ANDed with the interrupt enable.
- R7: The head entry is presented as timestamp low, descriptor 1, descriptor 2 and timestamp high. A pop strobe removes the head entry. A pop on an empty queue changes nothing.
- R8: Packet capture requests are accepted only while control bit 3 is set (pkt_tx_i high gives type 5, low gives type 4). They are ignored otherwise.
- R9: Requests waiting in the same cycle enter the queue one per cycle in fixed priority: software first, then packet, then hardware input 0 up to input 7.
- R10: An event that reaches a full queue is dropped, and so is a new request from a source whose previous event is still waiting. Either case sets the overflow flag, which stays set until reset.
- R11: While the queue is empty all four head words read as zero.
- R12: The stored timestamp is the time input sampled at the clock edge of the request. For a hardware input, this is the third rising clock edge after the input goes high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_now_i | input | 64 | Current time counter value |
| ctrl_i | input | 16 | Control: bit 3 packet capture enable, bits 15:8 hardware input enables |
| irq_en_i | input | 1 | Interrupt enable |
| sw_push_i | input | 1 | Software event request |
| hw_push_i | input | 8 | Asynchronous hardware edge inputs |
| pkt_req_i | input | 1 | Packet capture request |
| pkt_tx_i | input | 1 | 1 = transmit, 0 = receive |
| pkt_seq_i | input | 16 | Packet sequence ID |
| pkt_msg_i | input | 4 | Packet message type |
| pkt_port_i | input | 5 | Packet port number |
| pkt_dom_i | input | 8 | Packet domain |
| pop_i | input | 1 | Remove head entry |
| head_ts_lo_o | output | 32 | Head timestamp bits 31:0 |
| head_desc1_o | output | 32 | Head descriptor word 1 |
| head_desc2_o | output | 32 | Head descriptor word 2 |
| head_ts_hi_o | output | 32 | Head timestamp bits 63:32 |
| raw_pend_o | output | 1 | Queue non-empty |
| irq_o | output | 1 | Masked interrupt |
| overflow_o | output | 1 | Sticky drop flag |

## Verification
The bench aims at the sixteenth and seventeenth store. An off-by-one full test there would either lose the last good entry or store one into a slot already in use, and overflow would rise a step early or late. It fires every source in one cycle, so a wrong arbiter shows up as a reordered stream of event types. It holds a hardware input high and toggles its enable, so a level-sensitive or ungated capture shows up as extra entries. Back-to-back software requests, pops on an empty queue and packet requests with capture disabled are also driven, because a design that mishandles them corrupts the count or raises overflow without cause.

// File: rtl/ts_evt_pkg.sv
`timescale 1ns/1ps
package ts_evt_pkg;
  typedef enum logic [3:0] {
    EV_SW   = 4'd0,
    EV_ROLL = 4'd1,
    EV_HALF = 4'd2,
    EV_HW   = 4'd3,
    EV_RX   = 4'd4,
    EV_TX   = 4'd5,
    EV_CMP  = 4'd6,
    EV_HOST = 4'd7
  } ev_type_e;

  typedef struct packed {
    logic [63:0] ts;
    logic [4:0]  port;
    ev_type_e    etype;
    logic [3:0]  mtype;
    logic [15:0] seq;
    logic [7:0]  domain;
  } ev_rec_t;

  function automatic logic [31:0] pack_desc1(ev_rec_t r);
    return {3'b000, r.port, r.etype, r.mtype, r.seq};
  endfunction
endpackage

// File: rtl/ts_hw_edge.sv
`timescale 1ns/1ps
module ts_hw_edge #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1, s2, prv;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        prv <= 1'b0;
      end else begin
        s1  <= raw_i[g];
        s2  <= s1;
        prv <= s2;
      end
    end
    assign rise_o[g] = s2 & ~prv & en_i[g];
  end
endmodule

// File: rtl/ts_src_arb.sv
`timescale 1ns/1ps
module ts_src_arb
  import ts_evt_pkg::*;
#(
  parameter int N_SRC = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      req_i,
  input  ev_rec_t [N_SRC-1:0]   req_rec_i,
  input  logic                  full_i,
  output logic                  wr_o,
  output ev_rec_t               wr_rec_o,
  output logic                  drop_o
);
  logic [N_SRC-1:0] pend, gnt;
  ev_rec_t [N_SRC-1:0] rec;
  logic found;

  // lowest index wins
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (pend[s] && !found) begin
        gnt[s] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    wr_rec_o = '0;
    for (int s = 0; s < N_SRC; s++)
      if (gnt[s]) wr_rec_o = rec[s];
  end

  assign wr_o   = found & ~full_i;
  assign drop_o = (found & full_i) | (|(req_i & pend));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= '0;
      rec  <= '0;
    end else begin
      pend <= (pend & ~gnt) | (req_i & ~pend);
      for (int s = 0; s < N_SRC; s++)
        if (req_i[s] && !pend[s]) rec[s] <= req_rec_i[s];
    end
  end
endmodule

// File: rtl/ts_evt_queue.sv
`timescale 1ns/1ps
module ts_evt_queue
  import ts_evt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  ev_rec_t wr_rec_i,
  input  logic    pop_i,
  output logic    full_o,
  output logic    empty_o,
  output ev_rec_t head_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ev_rec_t       mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          we, re;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign we      = wr_i & ~full_o;
  assign re      = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (we) mem[wr_ptr] <= wr_rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (we) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (re) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({we, re})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ts_event_fifo.sv
`timescale 1ns/1ps
module ts_event_fifo
  import ts_evt_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int N_HW        = 8,
  parameter int RXTX_EN_BIT = 3,
  parameter int HW_EN_LSB   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [63:0]               ts_now_i,
  input  logic [HW_EN_LSB+N_HW-1:0] ctrl_i,
  input  logic                      irq_en_i,
  input  logic                      sw_push_i,
  input  logic [N_HW-1:0]           hw_push_i,
  input  logic                      pkt_req_i,
  input  logic                      pkt_tx_i,
  input  logic [15:0]               pkt_seq_i,
  input  logic [3:0]                pkt_msg_i,
  input  logic [4:0]                pkt_port_i,
  input  logic [7:0]                pkt_dom_i,
  input  logic                      pop_i,
  output logic [31:0]               head_ts_lo_o,
  output logic [31:0]               head_desc1_o,
  output logic [31:0]               head_desc2_o,
  output logic [31:0]               head_ts_hi_o,
  output logic                      raw_pend_o,
  output logic                      irq_o,
  output logic                      overflow_o
);
  localparam int N_SRC = N_HW + 2;
  localparam int SRC_SW  = 0;
  localparam int SRC_PKT = 1;
  localparam int SRC_HW0 = 2;

  logic [N_HW-1:0]   hw_rise;
  logic [N_SRC-1:0]  req;
  ev_rec_t [N_SRC-1:0] req_rec;
  ev_rec_t           wr_rec, head;
  logic              wr, drop, full, empty, ovf_q;

  ts_hw_edge #(.N(N_HW)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (hw_push_i),
    .en_i   (ctrl_i[HW_EN_LSB +: N_HW]),
    .rise_o (hw_rise)
  );

  always_comb begin
    req            = '0;
    req_rec        = '0;
    req[SRC_SW]    = sw_push_i;
    req_rec[SRC_SW].ts    = ts_now_i;
    req_rec[SRC_SW].etype = EV_SW;

    req[SRC_PKT]   = pkt_req_i & ctrl_i[RXTX_EN_BIT];
    req_rec[SRC_PKT].ts     = ts_now_i;
    req_rec[SRC_PKT].etype  = pkt_tx_i ? EV_TX : EV_RX;
    req_rec[SRC_PKT].mtype  = pkt_msg_i;
    req_rec[SRC_PKT].seq    = pkt_seq_i;
    req_rec[SRC_PKT].port   = pkt_port_i;
    req_rec[SRC_PKT].domain = pkt_dom_i;

    for (int i = 0; i < N_HW; i++) begin
      req[SRC_HW0+i]           = hw_rise[i];
      req_rec[SRC_HW0+i].ts    = ts_now_i;
      req_rec[SRC_HW0+i].etype = EV_HW;
      req_rec[SRC_HW0+i].port  = 5'(i + 1);
    end
  end

  ts_src_arb #(.N_SRC(N_SRC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .req_rec_i (req_rec),
    .full_i    (full),
    .wr_o      (wr),
    .wr_rec_o  (wr_rec),
    .drop_o    (drop)
  );

  ts_evt_queue #(.DEPTH(DEPTH)) u_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wr_rec_i (wr_rec),
    .pop_i    (pop_i),
    .full_o   (full),
    .empty_o  (empty),
    .head_o   (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  // empty queue reads as zero
  assign head_ts_lo_o = empty ? '0 : head.ts[31:0];
  assign head_ts_hi_o = empty ? '0 : head.ts[63:32];
  assign head_desc1_o = empty ? '0 : pack_desc1(head);
  assign head_desc2_o = empty ? '0 : {24'd0, head.domain};
  assign raw_pend_o   = ~empty;
  assign irq_o        = ~empty & irq_en_i;
  assign overflow_o   = ovf_q;
endmodule

// File: rtl/ts_event_fifo_chk.sv
`timescale 1ns/1ps
module ts_event_fifo_chk #(
  parameter int N_HW = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_en_i,
  input logic        pop_i,
  input logic [31:0] head_ts_lo_o,
  input logic [31:0] head_desc1_o,
  input logic [31:0] head_desc2_o,
  input logic [31:0] head_ts_hi_o,
  input logic        raw_pend_o,
  input logic        irq_o,
  input logic        overflow_o
);
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R6
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw_pend_o); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R10
  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_pend_o && !pop_i |=> raw_pend_o && $stable(head_ts_lo_o) && $stable(head_ts_hi_o)
      && $stable(head_desc1_o) && $stable(head_desc2_o)); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_pend_o |-> (head_ts_lo_o == 0 && head_ts_hi_o == 0 && head_desc1_o == 0
      && head_desc2_o == 0)); // R11
  AST_DESC1_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_pend_o |-> head_desc1_o[31:29] == 3'b000); // R2
  AST_DESC2_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_pend_o |-> head_desc2_o[31:8] == 24'd0); // R3
  AST_HW_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_pend_o && head_desc1_o[23:20] == 4'd3 |->
      (head_desc1_o[28:24] != 5'd0 && 32'(head_desc1_o[28:24]) <= N_HW)); // R5
  AST_SW_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_pend_o && head_desc1_o[23:20] == 4'd0 |-> head_desc1_o[28:0] == 29'd0); // R4
endmodule

bind ts_event_fifo ts_event_fifo_chk #(.N_HW(N_HW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_en_i     (irq_en_i),
  .pop_i        (pop_i),
  .head_ts_lo_o (head_ts_lo_o),
  .head_desc1_o (head_desc1_o),
  .head_desc2_o (head_desc2_o),
  .head_ts_hi_o (head_ts_hi_o),
  .raw_pend_o   (raw_pend_o),
  .irq_o        (irq_o),
  .overflow_o   (overflow_o)
);

// File: tb/ts_event_fifo_bench.sv
`timescale 1ns/1ps
module ts_event_fifo_bench;
  localparam int DEPTH = 16;
  localparam int N_HW  = 8;
  localparam int N_SRC = N_HW + 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] ts_now_i = 64'hA5A5_0001_0000_0000;
  logic [15:0] ctrl_i = '0;
  logic        irq_en_i = 1'b0;
  logic        sw_push_i = 1'b0;
  logic [7:0]  hw_push_i = '0;
  logic        pkt_req_i = 1'b0;
  logic        pkt_tx_i = 1'b0;
  logic [15:0] pkt_seq_i = '0;
  logic [3:0]  pkt_msg_i = '0;
  logic [4:0]  pkt_port_i = '0;
  logic [7:0]  pkt_dom_i = '0;
  logic        pop_i = 1'b0;
  logic [31:0] head_ts_lo_o, head_desc1_o, head_desc2_o, head_ts_hi_o;
  logic        raw_pend_o, irq_o, overflow_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;
  always @(negedge clk_i) ts_now_i <= ts_now_i + 64'd3;

  ts_event_fifo u_ts_event_fifo (.*);

  // reference model
  logic [103:0] mq[$];
  logic [7:0]   m_s1, m_s2, m_prv;
  logic         m_pend [N_SRC];
  logic [103:0] m_ent  [N_SRC];
  logic         m_ovf;

  always @(posedge clk_i) begin
    int g;
    logic full;
    logic pre [N_SRC];
    logic rq [N_SRC];
    logic [103:0] nw [N_SRC];
    if (!rst_ni) begin
      mq.delete();
      m_s1 = '0; m_s2 = '0; m_prv = '0; m_ovf = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin m_pend[s] = 1'b0; m_ent[s] = '0; end
    end else begin
      g = -1;
      for (int s = 0; s < N_SRC; s++) begin
        pre[s] = m_pend[s];
        if (m_pend[s] && g < 0) g = s;
      end
      full = (mq.size() == DEPTH);
      if (g >= 0 && full) m_ovf = 1'b1;
      if (pop_i && mq.size() > 0) void'(mq.pop_front());
      if (g >= 0 && !full) mq.push_back(m_ent[g]);
      if (g >= 0) m_pend[g] = 1'b0;
      rq[0] = sw_push_i;
      nw[0] = {ts_now_i, 32'd0, 8'd0};
      rq[1] = pkt_req_i & ctrl_i[3];
      nw[1] = {ts_now_i, 3'b0, pkt_port_i, (pkt_tx_i ? 4'd5 : 4'd4), pkt_msg_i, pkt_seq_i, pkt_dom_i};
      for (int i = 0; i < N_HW; i++) begin
        rq[2+i] = m_s2[i] & ~m_prv[i] & ctrl_i[8+i];
        nw[2+i] = {ts_now_i, 3'b0, 5'(i + 1), 4'd3, 4'd0, 16'd0, 8'd0};
      end
      for (int s = 0; s < N_SRC; s++) begin
        if (rq[s]) begin
          if (pre[s]) m_ovf = 1'b1;
          else begin m_pend[s] = 1'b1; m_ent[s] = nw[s]; end
        end
      end
      m_prv = m_s2; m_s2 = m_s1; m_s1 = hw_push_i;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [103:0] h;
    h = (mq.size() > 0) ? mq[0] : '0;   // R11 empty reads zero
    chk("R6 pending", 64'(raw_pend_o), 64'(mq.size() > 0));
    chk("R6 irq", 64'(irq_o), 64'((mq.size() > 0) && irq_en_i));
    chk("R2 desc1", 64'(head_desc1_o), 64'(h[39:8]));
    chk("R3 desc2", 64'(head_desc2_o), 64'({24'd0, h[7:0]}));
    chk("R12 timestamp", {head_ts_hi_o, head_ts_lo_o}, h[103:40]);
    chk("R10 overflow", 64'(overflow_o), 64'(m_ovf));
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic sw();
    sw_push_i = 1'b1; tick(); sw_push_i = 1'b0;
  endtask

  task automatic pkt(input logic tx, input logic [15:0] sq, input logic [3:0] mt,
                     input logic [4:0] pt, input logic [7:0] dm);
    pkt_req_i = 1'b1; pkt_tx_i = tx; pkt_seq_i = sq; pkt_msg_i = mt;
    pkt_port_i = pt; pkt_dom_i = dm;
    tick();
    pkt_req_i = 1'b0;
  endtask

  task automatic pop();
    pop_i = 1'b1; tick(); pop_i = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && raw_pend_o; k++) pop();
    idle(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d1;
    @(negedge clk_i);
    idle(3);
    chk("R11 reset head", 64'(head_desc1_o), 64'd0);
    chk("R6 reset pending", 64'(raw_pend_o), 64'd0);
    rst_ni = 1'b1;
    idle(2);

    // R4 software event, R7 pop and empty pop
    sw(); idle(2);
    chk("R4 sw type", 64'(head_desc1_o[23:20]), 64'd0);
    pop();
    chk("R7 pop empties", 64'(raw_pend_o), 64'd0);
    pop(); idle(1);
    chk("R7 empty pop ignored", 64'({raw_pend_o, overflow_o}), 64'd0);

    // R8 packet capture enabled
    ctrl_i = 16'h0008;
    pkt(1'b1, 16'hBEEF, 4'h3, 5'd2, 8'h55); idle(2);
    chk("R8 tx type", 64'(head_desc1_o[23:20]), 64'd5);
    chk("R2 tx layout", 64'(head_desc1_o), 64'h0253_BEEF);
    chk("R3 domain", 64'(head_desc2_o), 64'h55);
    pkt(1'b0, 16'h0102, 4'h9, 5'd17, 8'hC3); idle(2);
    pop();
    chk("R8 rx type", 64'(head_desc1_o[23:20]), 64'd4);
    drain();
    // R8 disabled
    ctrl_i = 16'h0000;
    pkt(1'b1, 16'h1111, 4'h1, 5'd1, 8'h01); idle(3);
    chk("R8 disabled ignored", 64'(raw_pend_o), 64'd0);

    // R5 hardware inputs, enables 0 and 2
    ctrl_i = 16'h0500;
    hw_push_i = 8'h07; idle(6);
    d1 = head_desc1_o; pop();
    chk("R5 first hw port", 64'({d1[28:24], d1[23:20]}), 64'({5'd1, 4'd3}));
    d1 = head_desc1_o; pop();
    chk("R5 second hw port", 64'({d1[28:24], d1[23:20]}), 64'({5'd3, 4'd3}));
    idle(5);
    chk("R5 held level no repeat", 64'(raw_pend_o), 64'd0);
    hw_push_i = 8'h00; idle(4);

    // R6 interrupt gating
    irq_en_i = 1'b1; sw(); idle(1);
    chk("R6 irq on", 64'(irq_o), 64'd1);
    irq_en_i = 1'b0; idle(1);
    chk("R6 irq masked", 64'(irq_o), 64'd0);
    drain();

    // R9 priority among simultaneous sources
    ctrl_i = 16'hFF08; irq_en_i = 1'b1;
    sw_push_i = 1'b1; pkt_req_i = 1'b1; pkt_tx_i = 1'b1; pkt_seq_i = 16'h0042;
    pkt_msg_i = 4'h0; pkt_port_i = 5'd4; pkt_dom_i = 8'h00;
    hw_push_i = 8'h28;
    tick();
    sw_push_i = 1'b0; pkt_req_i = 1'b0;
    idle(8);
    d1 = head_desc1_o; pop();
    chk("R9 order first", 64'(d1[23:20]), 64'd0);
    d1 = head_desc1_o; pop();
    chk("R9 order second", 64'(d1[23:20]), 64'd5);
    d1 = head_desc1_o; pop();
    chk("R9 order third", 64'(d1[28:20]), 64'({5'd4, 4'd3}));
    d1 = head_desc1_o; pop();
    chk("R9 order fourth", 64'(d1[28:20]), 64'({5'd6, 4'd3}));
    hw_push_i = 8'h00; idle(4);
    drain();

    // R1 fill to depth, R10 overflow on the next
    for (int k = 0; k < DEPTH; k++) begin sw(); idle(1); end
    idle(1);
    chk("R1 full no overflow", 64'({raw_pend_o, overflow_o}), 64'b10);
    sw(); idle(2);
    chk("R10 overflow on full", 64'(overflow_o), 64'd1);
    for (int k = 0; k < DEPTH; k++) pop();
    chk("R1 exactly depth stored", 64'(raw_pend_o), 64'd0);

    // R10 back-to-back request from one source
    rst_ni = 1'b0; idle(1); rst_ni = 1'b1; idle(1);
    chk("R10 reset clears", 64'(overflow_o), 64'd0);
    sw_push_i = 1'b1; idle(2); sw_push_i = 1'b0; idle(2);
    chk("R10 busy source drop", 64'(overflow_o), 64'd1);
    pop();
    chk("R10 one entry kept", 64'(raw_pend_o), 64'd0);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule